// File: doc/BRIEF.md
# I2C SCL Period Timing Generator

This block produces the serial clock waveform of an I2C master for standard, fast and high-speed operation. The requested bus rate selects the speed mode. The mode then sets a prescaled timing clock and a pair of low and high period counts. The low time is the loaded low count plus 7 timing ticks. The high time is the loaded high count plus 5 ticks.

When no board-supplied pair is present, the default counts come from the nominal rate of each mode. Standard mode uses a 1:1 duty ratio. Fast and high-speed modes use a 1:2 high-to-low ratio. A board can supply its own low and high durations for each of four timing sets: standard, fast, high-speed first phase and high-speed second phase. A supplied pair is used only when it is marked present, its low value exceeds 7 and its high value exceeds 5. The block then loads low−7 and high−5, so the bus sees exactly the supplied durations.

High-speed transfers start in a first phase, timed at the fast-mode rate from the fastest prescaled clock. A one-cycle pulse at the end of the master code moves the block to a second phase, timed directly from the functional clock, until the generator next goes idle. The framing logic around the block drives `run` high while a transfer needs clocking.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset and while `run` is low in idle, `scl_o` is 1 (released) and `phase_o` is 2'b00. Setting `run` starts a low phase at the next clock.
- R2: The mode is decoded from `rate_khz`. Values above 400 select high-speed, values above 100 up to 400 select fast, and values of 100 or less select standard.
- R3: With no override, a standard cycle is 20 low ticks and 20 high ticks of the 4000 kHz timing clock: 480/480 functional-clock cycles at 96 MHz.
- R4: With no override, a fast cycle is 16 low and 8 high ticks of the 9600 kHz timing clock: 160/80 functional-clock cycles.
- R5: With no override, the first high-speed phase is 32 low and 16 high ticks of the 19200 kHz timing clock: 160/80 functional-clock cycles.
- R6: From the next low phase after a one-cycle `hs_switch` pulse in high-speed mode, cycles are timed from the functional clock with 24 low and 12 high cycles (96000/2600 = 36, split 1:2). This holds until the block returns to idle.
- R7: Override set index 0 is standard, 1 is fast, 2 is the high-speed first phase and 3 is the second phase. When `ovr_ok[i]` is set, `ovr_low[i]` > 7 and `ovr_high[i]` > 5, the low and high durations equal `ovr_low[i]` and `ovr_high[i]` ticks. Otherwise the defaults apply.
- R8: Mode, phase and override values are taken only when a low phase starts. A change during a cycle leaves that cycle's low and high durations unchanged.
- R9: When `run` falls, the current cycle completes with its full high phase. The block then enters idle with SCL released and drops back to the first high-speed phase.
- R10: `phase_o` is 2'b01 in the low phase, where `scl_o` is 0, and 2'b10 in the high phase, where `scl_o` is 1. Every low phase lasts at least 7 functional-clock cycles and every high phase at least 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock (96 MHz by default) |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep generating SCL cycles |
| rate_khz | input | 16 | Requested bus rate in kHz; selects the mode |
| hs_switch | input | 1 | One-cycle pulse at the end of the master code |
| ovr_low | input | 4x8 | Board-supplied low durations, one per timing set |
| ovr_high | input | 4x8 | Board-supplied high durations, one per timing set |
| ovr_ok | input | 4 | Presence flag of each supplied pair |
| scl_o | output | 1 | SCL level: 0 drives low, 1 releases |
| phase_o | output | 2 | 00 idle, 01 low, 10 high |

## Verification
The bench measures the low and high durations on `scl_o` in functional-clock cycles. It compares them with values worked out from the requirements. The rates 100, 101, 400 and 401 are driven with an override loaded only on the high-speed first-phase set. Fast and first-phase defaults give the same 160/80 durations, so only the override can show which decode was taken. Override pairs sit at and just past the 7/5 thresholds, and a good pair is also tried with its flag cleared, to show where the fallback applies. Rate changes and `hs_switch` pulses are placed inside a running cycle to show that a cycle is never altered partway through. Dropping `run` checks that the high-speed phase state is cleared.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;

    localparam int CNT_W    = 8;
    localparam int PRE_W    = 8;
    localparam int NSET     = 4;
    localparam int LOW_OFS  = 7;
    localparam int HIGH_OFS = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        SET_STD  = 2'd0,
        SET_FAST = 2'd1,
        SET_HS1  = 2'd2,
        SET_HS2  = 2'd3
    } set_e;

    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic [CNT_W-1:0] lo_reg;
        logic [CNT_W-1:0] hi_reg;
    } tcfg_t;

    function automatic int sat_sub(int a, int b);
        return (a > b) ? a - b : 0;
    endfunction

    // Register value for one half period: duty split, then offset removed (clamped at zero).
    function automatic int def_count(int clk_khz, int rate_khz, bit even, bit high);
        int scl;
        int raw;
        scl = clk_khz / rate_khz;
        if (even) raw = clk_khz / (2 * rate_khz);
        else      raw = high ? scl / 3 : scl - scl / 3;
        return sat_sub(raw, high ? HIGH_OFS : LOW_OFS);
    endfunction

    function automatic int div_of(int fclk_khz, int tclk_khz);
        return (fclk_khz / tclk_khz < 1) ? 1 : fclk_khz / tclk_khz;
    endfunction

endpackage

// File: rtl/scl_cfg_select.sv
module scl_cfg_select
    import scl_tim_pkg::*;
#(
    parameter int FCLK_KHZ      = 96000,
    parameter int STD_CLK_KHZ   = 4000,
    parameter int FAST_CLK_KHZ  = 9600,
    parameter int HS_CLK_KHZ    = 19200,
    parameter int STD_RATE_KHZ  = 100,
    parameter int FAST_RATE_KHZ = 400,
    parameter int HS_RATE_KHZ   = 2600,
    parameter int RATE_W        = 16
) (
    input  logic [RATE_W-1:0]           rate_khz,
    input  logic                        hs2,
    input  logic [NSET-1:0][CNT_W-1:0]  ovr_low,
    input  logic [NSET-1:0][CNT_W-1:0]  ovr_high,
    input  logic [NSET-1:0]             ovr_ok,
    output tcfg_t                       cfg
);
    localparam int DEF_LO [NSET] = '{
        def_count(STD_CLK_KHZ,  STD_RATE_KHZ,  1'b1, 1'b0),
        def_count(FAST_CLK_KHZ, FAST_RATE_KHZ, 1'b0, 1'b0),
        def_count(HS_CLK_KHZ,   FAST_RATE_KHZ, 1'b0, 1'b0),
        def_count(FCLK_KHZ,     HS_RATE_KHZ,   1'b0, 1'b0)};
    localparam int DEF_HI [NSET] = '{
        def_count(STD_CLK_KHZ,  STD_RATE_KHZ,  1'b1, 1'b1),
        def_count(FAST_CLK_KHZ, FAST_RATE_KHZ, 1'b0, 1'b1),
        def_count(HS_CLK_KHZ,   FAST_RATE_KHZ, 1'b0, 1'b1),
        def_count(FCLK_KHZ,     HS_RATE_KHZ,   1'b0, 1'b1)};
    localparam int DIV [NSET] = '{
        div_of(FCLK_KHZ, STD_CLK_KHZ),
        div_of(FCLK_KHZ, FAST_CLK_KHZ),
        div_of(FCLK_KHZ, HS_CLK_KHZ),
        1};

    logic [CNT_W-1:0] lo_sel  [NSET];
    logic [CNT_W-1:0] hi_sel  [NSET];
    logic [PRE_W-1:0] div_sel [NSET];
    set_e             idx;

    for (genvar g = 0; g < NSET; g++) begin : g_set
        logic take;
        assign take = ovr_ok[g]
                   && (ovr_low[g]  > CNT_W'(LOW_OFS))
                   && (ovr_high[g] > CNT_W'(HIGH_OFS));
        assign lo_sel[g]  = take ? ovr_low[g]  - CNT_W'(LOW_OFS)  : CNT_W'(DEF_LO[g]);
        assign hi_sel[g]  = take ? ovr_high[g] - CNT_W'(HIGH_OFS) : CNT_W'(DEF_HI[g]);
        assign div_sel[g] = PRE_W'(DIV[g]);
    end

    always_comb begin
        if (rate_khz > RATE_W'(FAST_RATE_KHZ))     idx = hs2 ? SET_HS2 : SET_HS1;
        else if (rate_khz > RATE_W'(STD_RATE_KHZ)) idx = SET_FAST;
        else                                       idx = SET_STD;
        cfg.div    = div_sel[idx];
        cfg.lo_reg = lo_sel[idx];
        cfg.hi_reg = hi_sel[idx];
    end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pre;

    assign tick = en && (pre == div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en) pre <= '0;
        else if (tick)  pre <= '0;
        else            pre <= pre + 1'b1;
    end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_tim_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   hs_switch,
    input  logic   tick,
    input  tcfg_t  cfg_next,
    output tcfg_t  cfg_q,
    output phase_e phase,
    output logic   hs2
);
    localparam int LD_W = CNT_W + 1;

    logic [LD_W-1:0] cnt;
    logic            last;
    logic [LD_W-1:0] lo_load;
    logic [LD_W-1:0] hi_load;

    assign last    = tick && (cnt == '0);
    assign lo_load = {1'b0, cfg_next.lo_reg} + LD_W'(LOW_OFS - 1);
    assign hi_load = {1'b0, cfg_q.hi_reg}    + LD_W'(HIGH_OFS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (run) begin
                    phase <= PH_LOW;
                    cfg_q <= cfg_next;
                    cnt   <= lo_load;
                end
                PH_LOW: if (last) begin
                    phase <= PH_HIGH;
                    cnt   <= hi_load;
                end else if (tick) begin
                    cnt <= cnt - 1'b1;
                end
                PH_HIGH: if (last) begin
                    if (run) begin
                        phase <= PH_LOW;
                        cfg_q <= cfg_next;
                        cnt   <= lo_load;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end else if (tick) begin
                    cnt <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                   hs2 <= 1'b0;
        else if (phase == PH_HIGH && last && !run) hs2 <= 1'b0;
        else if (hs_switch && phase != PH_IDLE)    hs2 <= 1'b1;
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tim_pkg::*;
#(
    parameter int FCLK_KHZ      = 96000,
    parameter int STD_CLK_KHZ   = 4000,
    parameter int FAST_CLK_KHZ  = 9600,
    parameter int HS_CLK_KHZ    = 19200,
    parameter int STD_RATE_KHZ  = 100,
    parameter int FAST_RATE_KHZ = 400,
    parameter int HS_RATE_KHZ   = 2600,
    parameter int RATE_W        = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        run,
    input  logic [RATE_W-1:0]           rate_khz,
    input  logic                        hs_switch,
    input  logic [NSET-1:0][CNT_W-1:0]  ovr_low,
    input  logic [NSET-1:0][CNT_W-1:0]  ovr_high,
    input  logic [NSET-1:0]             ovr_ok,
    output logic                        scl_o,
    output logic [1:0]                  phase_o
);
    tcfg_t  cfg_next;
    tcfg_t  cfg_q;
    phase_e phase;
    logic   hs2;
    logic   tick;

    scl_cfg_select #(
        .FCLK_KHZ(FCLK_KHZ), .STD_CLK_KHZ(STD_CLK_KHZ), .FAST_CLK_KHZ(FAST_CLK_KHZ),
        .HS_CLK_KHZ(HS_CLK_KHZ), .STD_RATE_KHZ(STD_RATE_KHZ),
        .FAST_RATE_KHZ(FAST_RATE_KHZ), .HS_RATE_KHZ(HS_RATE_KHZ), .RATE_W(RATE_W)
    ) u_sel (
        .rate_khz(rate_khz), .hs2(hs2), .ovr_low(ovr_low),
        .ovr_high(ovr_high), .ovr_ok(ovr_ok), .cfg(cfg_next)
    );

    scl_prescaler u_pre (
        .clk(clk), .rst(rst), .en(phase != PH_IDLE), .div(cfg_q.div), .tick(tick)
    );

    scl_phase_seq u_seq (
        .clk(clk), .rst(rst), .run(run), .hs_switch(hs_switch), .tick(tick),
        .cfg_next(cfg_next), .cfg_q(cfg_q), .phase(phase), .hs2(hs2)
    );

    assign scl_o   = (phase != PH_LOW);
    assign phase_o = phase;

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
    import scl_tim_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       run,
    input logic       scl_o,
    input logic [1:0] phase_o
);
    logic [15:0] lo_len;
    logic [15:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_len <= '0;
            hi_len <= '0;
        end else begin
            lo_len <= (phase_o == PH_LOW)  ? lo_len + 1'b1 : '0;
            hi_len <= (phase_o == PH_HIGH) ? hi_len + 1'b1 : '0;
        end
    end

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_IDLE && !run) |=> (phase_o == PH_IDLE));

    a_r9_low_never_idles: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_LOW) |=> (phase_o != PH_IDLE));

    a_r10_idle_enters_low: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_IDLE) |=> (phase_o == PH_IDLE || phase_o == PH_LOW));

    a_r10_min_low: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_HIGH && lo_len != 0) |-> (lo_len >= 16'(LOW_OFS)));

    a_r10_min_high: assert property (@(posedge clk) disable iff (rst)
        (phase_o != PH_HIGH && hi_len != 0) |-> (hi_len >= 16'(HIGH_OFS)));

    a_r10_scl_follows_phase: assert property (@(posedge clk) disable iff (rst)
        $stable(phase_o) |-> $stable(scl_o));

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk(clk), .rst(rst), .run(run), .scl_o(scl_o), .phase_o(phase_o)
);

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
    logic            clk = 1'b0;
    logic            rst;
    logic            run;
    logic [15:0]     rate_khz;
    logic            hs_switch;
    logic [3:0][7:0] ovr_low;
    logic [3:0][7:0] ovr_high;
    logic [3:0]      ovr_ok;
    logic            scl_o;
    logic [1:0]      phase_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scl_timing_gen u0 (
        .clk(clk), .rst(rst), .run(run), .rate_khz(rate_khz), .hs_switch(hs_switch),
        .ovr_low(ovr_low), .ovr_high(ovr_high), .ovr_ok(ovr_ok),
        .scl_o(scl_o), .phase_o(phase_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Skip the current low, then time the next full low and high phase.
    task automatic measure(output int lo, output int hi);
        @(negedge clk);
        while (scl_o == 1'b0) @(negedge clk);
        while (scl_o == 1'b1) @(negedge clk);
        lo = 0;
        while (scl_o == 1'b0) begin lo++; @(negedge clk); end
        hi = 0;
        while (phase_o == 2'b10) begin hi++; @(negedge clk); end
    endtask

    task automatic expect_cycle(input string req, input int elo, input int ehi);
        int lo, hi;
        measure(lo, hi);
        chk({req, " low"}, lo, elo);
        chk({req, " high"}, hi, ehi);
    endtask

    task automatic t_reset();
        chk("R1 scl after reset", int'(scl_o), 1);
        chk("R1 phase after reset", int'(phase_o), 0);
        repeat (50) @(negedge clk);
        chk("R1 idle while run low", int'(phase_o), 0);
        run = 1'b1;
        @(negedge clk);
        chk("R1 low starts after run", int'(phase_o), 1);
    endtask

    task automatic t_std();
        rate_khz = 16'd100;
        expect_cycle("R3 standard default", 480, 480);
        chk("R10 phase code in low", int'(phase_o), 1);
        chk("R10 scl in low", int'(scl_o), 0);
        while (phase_o == 2'b01) @(negedge clk);
        chk("R10 phase code in high", int'(phase_o), 2);
        chk("R10 scl in high", int'(scl_o), 1);
    endtask

    task automatic t_fast();
        rate_khz = 16'd101;
        expect_cycle("R4 fast default at 101", 160, 80);
    endtask

    task automatic t_decode();
        ovr_ok[2] = 1'b1; ovr_low[2] = 8'd40; ovr_high[2] = 8'd30;
        rate_khz = 16'd100;
        expect_cycle("R2 rate 100 is standard", 480, 480);
        rate_khz = 16'd400;
        expect_cycle("R2 rate 400 is fast", 160, 80);
        rate_khz = 16'd401;
        expect_cycle("R2 rate 401 is high-speed", 200, 150);
        ovr_ok[2] = 1'b0;
        expect_cycle("R5 high-speed phase1 default", 160, 80);
    endtask

    task automatic t_override();
        rate_khz = 16'd100;
        ovr_ok[0] = 1'b1; ovr_low[0] = 8'd30; ovr_high[0] = 8'd25;
        expect_cycle("R7 standard override 30/25", 720, 600);
        ovr_ok[0] = 1'b0;
        rate_khz = 16'd400;
        ovr_ok[1] = 1'b1; ovr_low[1] = 8'd7; ovr_high[1] = 8'd6;
        expect_cycle("R7 low 7 falls back", 160, 80);
        ovr_low[1] = 8'd8; ovr_high[1] = 8'd5;
        expect_cycle("R7 high 5 falls back", 160, 80);
        ovr_low[1] = 8'd8; ovr_high[1] = 8'd6;
        expect_cycle("R7 fast override 8/6", 80, 60);
        ovr_ok[1] = 1'b0; ovr_low[1] = 8'd50; ovr_high[1] = 8'd50;
        expect_cycle("R7 flag clear falls back", 160, 80);
    endtask

    task automatic t_latch();
        int lo, hi;
        rate_khz = 16'd100;
        measure(lo, hi);
        lo = 0;
        while (scl_o == 1'b0) begin
            lo++;
            if (lo == 100) rate_khz = 16'd400;
            @(negedge clk);
        end
        hi = 0;
        while (phase_o == 2'b10) begin hi++; @(negedge clk); end
        chk("R8 low kept after mid-cycle change", lo, 480);
        chk("R8 high kept after mid-cycle change", hi, 480);
        expect_cycle("R8 change applied next cycle", 160, 80);
    endtask

    task automatic t_hs();
        int lo, hi;
        rate_khz = 16'd2600;
        expect_cycle("R5 high-speed phase1", 160, 80);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        expect_cycle("R6 high-speed phase2 default", 24, 12);
        expect_cycle("R6 phase2 persists", 24, 12);
        ovr_ok[3] = 1'b1; ovr_low[3] = 8'd40; ovr_high[3] = 8'd20;
        expect_cycle("R7 phase2 override 40/20", 40, 20);
        ovr_ok[3] = 1'b0;
        measure(lo, hi);
    endtask

    task automatic t_stop();
        int n;
        run = 1'b0;
        n = 0;
        while (phase_o != 2'b00 && n < 1000) begin n++; @(negedge clk); end
        chk("R9 idle right after current cycle", int'(n <= 36), 1);
        chk("R9 final high completed", int'(n >= 12), 1);
        repeat (40) @(negedge clk);
        chk("R9 scl released in idle", int'(scl_o), 1);
        chk("R9 phase idle", int'(phase_o), 0);
        run = 1'b1;
        expect_cycle("R9 restart in phase1", 160, 80);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1-wide: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; run = 1'b0; rate_khz = 16'd100; hs_switch = 1'b0;
        ovr_low = '0; ovr_high = '0; ovr_ok = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_std();
        t_fast();
        t_decode();
        t_override();
        t_latch();
        t_hs();
        t_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule